// File: doc/BRIEF.md
# Core Power Gating Sequencer

This block steps a single CPU core's power domain through a controlled shutdown or wake-up. It drives four per-core controls: isolation, the power-switch request, the power-good indication and the core's power-on-reset hold. After each control change that needs confirmation, it watches a per-core acknowledge input until that acknowledge agrees or a poll budget runs out. Whether an exhausted budget is fatal depends on the step. A request names a cluster, a core within that cluster and a direction. Completion is reported with a one-cycle `seq_done` pulse and failure with a one-cycle `seq_err` pulse.

A second entry point, `boot_start`, runs an early-boot sweep that switches off every core except core 0. The `single_cluster` strap limits the sweep to the first cluster. Only one operation runs at a time. While an operation or a sweep is active, further starts are dropped.

Top module: `core_pwr_seq`

## Requirements
- R1: After reset every core is in the running state: `iso_en`=0, `pwr_sw_req`=1, `pwr_ready`=1, `por_hold`=0. `busy`, `seq_done` and `seq_err` are all 0.
- R2: The target core index is cluster × CORES_PER_CLUSTER + local core (defaults 2 per cluster, 4 cores). Only that core's outputs change.
- R3: Power-down changes the target core's outputs in this order: set isolation; confirm `iso_ack`=1; clear the switch request; confirm `sw_ack`=0; clear power-good; set reset hold; confirm `por_ack`=1. With acknowledges that follow the outputs after L cycles, `seq_done` appears 7+3L cycles after the request edge.
- R4: Power-up changes the target core's outputs in this order: set the switch request; wait SETTLE_US × CLKS_PER_US cycles; set power-good; confirm `rdy_ack`=1, staying at least MIN_RDY_CYCLES (16) cycles in that wait; clear isolation; confirm `iso_ack`=0; clear reset hold; confirm `por_ack`=0. `seq_done` appears 6+S+2L+max(L+1,16) cycles after the request edge.
- R5: Each confirmation wait polls once per cycle, for at most POLL_LIMIT (2000) cycles. When the wait expires, its budget is spent.
- R6: In power-down, an expired switch-clear wait or reset-hold wait ends with `seq_err` and leaves the later steps undone. An expired isolation wait is tolerated and the sequence continues.
- R7: In power-up, an expired power-good wait or reset-release wait ends with `seq_err`. An expired isolation-clear wait is tolerated.
- R8: `boot_start` powers down cores 1..3 in ascending order, or only core 1 when `single_cluster`=1. It gives one `seq_done` at the end of the whole sweep and stops at the first `seq_err`. Consecutive cores start 9 cycles apart.
- R9: `req_valid` and `boot_start` are ignored while `busy`=1. `busy` is 1 from the cycle after acceptance until the final pulse.
- R10: `seq_done` and `seq_err` are single-cycle pulses that never coincide. `busy` is 0 in the cycle after either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a single-core operation |
| req_cluster | input | 1 | Cluster number of the target |
| req_local | input | 1 | Core number within the cluster |
| req_up | input | 1 | 1 = power up, 0 = power down |
| boot_start | input | 1 | Start the early-boot power-down sweep |
| single_cluster | input | 1 | Strap: only the first cluster exists |
| iso_ack | input | 4 | Per-core isolation status |
| sw_ack | input | 4 | Per-core power-switch status |
| rdy_ack | input | 4 | Per-core power-good status |
| por_ack | input | 4 | Per-core reset-hold status |
| iso_en | output | 4 | Per-core isolation enable |
| pwr_sw_req | output | 4 | Per-core power-switch request (1 = on) |
| pwr_ready | output | 4 | Per-core power-good indication |
| por_hold | output | 4 | Per-core power-on reset hold (1 = held) |
| busy | output | 1 | Operation or sweep in progress |
| seq_done | output | 1 | One-cycle success pulse |
| seq_err | output | 1 | One-cycle failure pulse |

## Verification
Each result has a due cycle counted from the clock edge that accepts the start. A power-down finishes at 7+3L. A power-up finishes at 6+S+2L+max(L+1,16). An error from a stuck acknowledge is due exactly POLL_LIMIT cycles into the wait where it stalls, and sweep members follow each other every 9 cycles. The bench gives its acknowledge model a programmable delay L and per-core stuck overrides. It counts falling edges from the accepting edge and compares the count at which a pulse first appears with these formulas. This rejects early, late and spurious pulses alike. On the next falling edge it checks that the pulse has dropped and `busy` has cleared.

// File: rtl/pwr_seq_pkg.sv
// Shared types of the core power gating sequencer.
// Assumes: nothing beyond the 2017 language standard.
package pwr_seq_pkg;

    // Sequencer states; action states last one cycle, wait states poll.
    typedef enum logic [4:0] {
        S_IDLE,
        S_DN_ISO, S_DN_ISO_W, S_DN_SW, S_DN_SW_W, S_DN_RDY, S_DN_POR, S_DN_POR_W,
        S_UP_SW, S_UP_SETTLE, S_UP_RDY, S_UP_RDY_W, S_UP_ISO, S_UP_ISO_W,
        S_UP_POR, S_UP_POR_W,
        S_DONE, S_FAIL
    } seq_state_e;

    // Single control change applied to the addressed core.
    typedef enum logic [3:0] {
        ACT_NONE,
        ACT_ISO_SET, ACT_ISO_CLR,
        ACT_SW_SET,  ACT_SW_CLR,
        ACT_RDY_SET, ACT_RDY_CLR,
        ACT_POR_SET, ACT_POR_CLR
    } pwr_act_e;

endpackage

// File: rtl/pwr_req_front.sv
// Request front end: turns a cluster/local pair into a core index, runs the
// early-boot sweep and filters starts while anything is in flight.
// Assumes: the step engine pulses seq_ok/seq_fail for one cycle and is idle
// the cycle after.
module pwr_req_front #(
    parameter int NUM_CORES         = 4,
    parameter int CORES_PER_CLUSTER = 2,
    parameter int IDXW              = 2,
    parameter int CLW               = 1,
    parameter int LCW               = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [CLW-1:0]  req_cluster,
    input  logic [LCW-1:0]  req_local,
    input  logic            req_up,
    input  logic            boot_start,
    input  logic            single_cluster,
    input  logic            seq_idle,
    input  logic            seq_ok,
    input  logic            seq_fail,
    output logic            launch,
    output logic [IDXW-1:0] launch_core,
    output logic            launch_up,
    output logic            hold_busy,
    output logic            done,
    output logic            err
);
    logic            sweep_act;
    logic            pend;
    logic [IDXW-1:0] sweep_core;
    logic [IDXW-1:0] sweep_last;
    logic [IDXW-1:0] req_idx;
    logic            accept;
    logic            boot_go;
    logic            last_hit;

    // Absolute core number from the cluster and local fields.
    assign req_idx = IDXW'(int'(req_cluster) * CORES_PER_CLUSTER + int'(req_local));

    assign accept   = seq_idle && !pend && !sweep_act;
    assign boot_go  = accept && boot_start;
    assign last_hit = (sweep_core == sweep_last);

    // Pick the next start: a pending sweep step, then a sweep, then a request.
    always_comb begin
        launch      = 1'b0;
        launch_core = req_idx;
        launch_up   = req_up;
        if (pend && seq_idle) begin
            launch      = 1'b1;
            launch_core = sweep_core;
            launch_up   = 1'b0;
        end else if (boot_go) begin
            launch      = 1'b1;
            launch_core = IDXW'(1);
            launch_up   = 1'b0;
        end else if (accept && req_valid) begin
            launch      = 1'b1;
        end
    end

    // Track the sweep position and whether another member must start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sweep_act  <= 1'b0;
            pend       <= 1'b0;
            sweep_core <= '0;
            sweep_last <= '0;
        end else begin
            if (boot_go) begin
                sweep_act  <= 1'b1;
                sweep_core <= IDXW'(1);
                sweep_last <= single_cluster ? IDXW'(CORES_PER_CLUSTER - 1)
                                             : IDXW'(NUM_CORES - 1);
            end
            if (pend && seq_idle) pend <= 1'b0;
            if (seq_ok && sweep_act) begin
                if (last_hit) begin
                    sweep_act <= 1'b0;
                end else begin
                    sweep_core <= sweep_core + 1'b1;
                    pend       <= 1'b1;
                end
            end
            if (seq_fail) begin
                sweep_act <= 1'b0;
                pend      <= 1'b0;
            end
        end
    end

    assign hold_busy = pend || sweep_act;
    assign done      = seq_ok && (!sweep_act || last_hit);
    assign err       = seq_fail;

endmodule

// File: rtl/pwr_step_fsm.sv
// Step engine: walks the power-down or power-up order for one core, polls
// the matching acknowledge with a bounded budget and decides abort versus
// continue on expiry.
// Assumes: SETTLE_CYC >= 1, POLL_LIMIT >= 1, acknowledges are synchronous.
module pwr_step_fsm
    import pwr_seq_pkg::*;
#(
    parameter int NUM_CORES      = 4,
    parameter int IDXW           = 2,
    parameter int SETTLE_CYC     = 20000,
    parameter int POLL_LIMIT     = 2000,
    parameter int MIN_RDY_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 launch,
    input  logic [IDXW-1:0]      launch_core,
    input  logic                 launch_up,
    input  logic [NUM_CORES-1:0] iso_ack,
    input  logic [NUM_CORES-1:0] sw_ack,
    input  logic [NUM_CORES-1:0] rdy_ack,
    input  logic [NUM_CORES-1:0] por_ack,
    output pwr_act_e             act,
    output logic [IDXW-1:0]      act_core,
    output logic                 idle,
    output logic                 seq_ok,
    output logic                 seq_fail
);
    localparam int MAXC = (POLL_LIMIT > SETTLE_CYC) ? POLL_LIMIT : SETTLE_CYC;
    localparam int CNTW = $clog2(MAXC + 1);
    localparam int DWW  = $clog2(MIN_RDY_CYCLES + 1);

    seq_state_e      state;
    logic [IDXW-1:0] core_r;
    logic [CNTW-1:0] cnt;
    logic [DWW-1:0]  dwell;
    logic            a_iso, a_sw, a_rdy, a_por;
    logic            last;

    assign a_iso = iso_ack[core_r];
    assign a_sw  = sw_ack[core_r];
    assign a_rdy = rdy_ack[core_r];
    assign a_por = por_ack[core_r];
    assign last  = (cnt == CNTW'(1));

    // Advance through the ordered steps and run the poll/settle counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            core_r <= '0;
            cnt    <= '0;
            dwell  <= '0;
        end else begin
            case (state)
                S_IDLE: if (launch) begin
                    core_r <= launch_core;
                    state  <= launch_up ? S_UP_SW : S_DN_ISO;
                end
                S_DN_ISO: begin
                    cnt   <= CNTW'(POLL_LIMIT);
                    state <= S_DN_ISO_W;
                end
                S_DN_ISO_W: begin
                    if (a_iso || last) state <= S_DN_SW;
                    else               cnt   <= cnt - 1'b1;
                end
                S_DN_SW: begin
                    cnt   <= CNTW'(POLL_LIMIT);
                    state <= S_DN_SW_W;
                end
                S_DN_SW_W: begin
                    if (!a_sw)     state <= S_DN_RDY;
                    else if (last) state <= S_FAIL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_DN_RDY: state <= S_DN_POR;
                S_DN_POR: begin
                    cnt   <= CNTW'(POLL_LIMIT);
                    state <= S_DN_POR_W;
                end
                S_DN_POR_W: begin
                    if (a_por)     state <= S_DONE;
                    else if (last) state <= S_FAIL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_UP_SW: begin
                    cnt   <= CNTW'(SETTLE_CYC - 1);
                    state <= S_UP_SETTLE;
                end
                S_UP_SETTLE: begin
                    if (cnt == '0) state <= S_UP_RDY;
                    else           cnt   <= cnt - 1'b1;
                end
                S_UP_RDY: begin
                    cnt   <= CNTW'(POLL_LIMIT);
                    dwell <= '0;
                    state <= S_UP_RDY_W;
                end
                S_UP_RDY_W: begin
                    if (dwell != DWW'(MIN_RDY_CYCLES)) dwell <= dwell + 1'b1;
                    if (a_rdy && (dwell >= DWW'(MIN_RDY_CYCLES - 1))) state <= S_UP_ISO;
                    else if (last) state <= S_FAIL;
                    else           cnt   <= cnt - 1'b1;
                end
                S_UP_ISO: begin
                    cnt   <= CNTW'(POLL_LIMIT);
                    state <= S_UP_ISO_W;
                end
                S_UP_ISO_W: begin
                    if (!a_iso || last) state <= S_UP_POR;
                    else                cnt   <= cnt - 1'b1;
                end
                S_UP_POR: begin
                    cnt   <= CNTW'(POLL_LIMIT);
                    state <= S_UP_POR_W;
                end
                S_UP_POR_W: begin
                    if (!a_por)    state <= S_DONE;
                    else if (last) state <= S_FAIL;
                    else           cnt   <= cnt - 1'b1;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Translate each action state into the control change it applies.
    always_comb begin
        act = ACT_NONE;
        case (state)
            S_DN_ISO: act = ACT_ISO_SET;
            S_DN_SW:  act = ACT_SW_CLR;
            S_DN_RDY: act = ACT_RDY_CLR;
            S_DN_POR: act = ACT_POR_SET;
            S_UP_SW:  act = ACT_SW_SET;
            S_UP_RDY: act = ACT_RDY_SET;
            S_UP_ISO: act = ACT_ISO_CLR;
            S_UP_POR: act = ACT_POR_CLR;
            default:  act = ACT_NONE;
        endcase
    end

    assign act_core = core_r;
    assign idle     = (state == S_IDLE);
    assign seq_ok   = (state == S_DONE);
    assign seq_fail = (state == S_FAIL);

endmodule

// File: rtl/pwr_core_regs.sv
// Per-core control registers: one replica per core holds isolation, switch
// request, power-good and reset hold, updated only when addressed.
// Assumes: at most one action per cycle; cores come out of reset running.
module pwr_core_regs
    import pwr_seq_pkg::*;
#(
    parameter int NUM_CORES = 4,
    parameter int IDXW      = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  pwr_act_e             act,
    input  logic [IDXW-1:0]      act_core,
    output logic [NUM_CORES-1:0] iso_en,
    output logic [NUM_CORES-1:0] pwr_sw_req,
    output logic [NUM_CORES-1:0] pwr_ready,
    output logic [NUM_CORES-1:0] por_hold
);
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        // Apply the current action when this replica is the addressed core.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                iso_en[g]     <= 1'b0;
                pwr_sw_req[g] <= 1'b1;
                pwr_ready[g]  <= 1'b1;
                por_hold[g]   <= 1'b0;
            end else if (act_core == IDXW'(g)) begin
                case (act)
                    ACT_ISO_SET: iso_en[g]     <= 1'b1;
                    ACT_ISO_CLR: iso_en[g]     <= 1'b0;
                    ACT_SW_SET:  pwr_sw_req[g] <= 1'b1;
                    ACT_SW_CLR:  pwr_sw_req[g] <= 1'b0;
                    ACT_RDY_SET: pwr_ready[g]  <= 1'b1;
                    ACT_RDY_CLR: pwr_ready[g]  <= 1'b0;
                    ACT_POR_SET: por_hold[g]   <= 1'b1;
                    ACT_POR_CLR: por_hold[g]   <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/core_pwr_seq.sv
// Top of the core power gating sequencer: front end, step engine and the
// per-core control registers.
// Assumes: NUM_CORES is a multiple of CORES_PER_CLUSTER, with at least two
// clusters and two cores per cluster for the default port widths.
module core_pwr_seq #(
    parameter int NUM_CORES         = 4,
    parameter int CORES_PER_CLUSTER = 2,
    parameter int CLKS_PER_US       = 200,
    parameter int SETTLE_US         = 100,
    parameter int POLL_LIMIT        = 2000,
    parameter int MIN_RDY_CYCLES    = 16
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic                                           req_valid,
    input  logic [$clog2(NUM_CORES/CORES_PER_CLUSTER)-1:0] req_cluster,
    input  logic [$clog2(CORES_PER_CLUSTER)-1:0]           req_local,
    input  logic                                           req_up,
    input  logic                                           boot_start,
    input  logic                                           single_cluster,
    input  logic [NUM_CORES-1:0]                           iso_ack,
    input  logic [NUM_CORES-1:0]                           sw_ack,
    input  logic [NUM_CORES-1:0]                           rdy_ack,
    input  logic [NUM_CORES-1:0]                           por_ack,
    output logic [NUM_CORES-1:0]                           iso_en,
    output logic [NUM_CORES-1:0]                           pwr_sw_req,
    output logic [NUM_CORES-1:0]                           pwr_ready,
    output logic [NUM_CORES-1:0]                           por_hold,
    output logic                                           busy,
    output logic                                           seq_done,
    output logic                                           seq_err
);
    import pwr_seq_pkg::*;

    localparam int IDXW       = $clog2(NUM_CORES);
    localparam int CLW        = $clog2(NUM_CORES / CORES_PER_CLUSTER);
    localparam int LCW        = $clog2(CORES_PER_CLUSTER);
    localparam int SETTLE_CYC = CLKS_PER_US * SETTLE_US;

    logic            launch, launch_up, hold_busy;
    logic [IDXW-1:0] launch_core, act_core;
    logic            seq_idle, seq_ok, seq_fail;
    pwr_act_e        act;

    pwr_req_front #(
        .NUM_CORES(NUM_CORES), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
        .IDXW(IDXW), .CLW(CLW), .LCW(LCW)
    ) front_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .req_cluster(req_cluster), .req_local(req_local), .req_up(req_up),
        .boot_start(boot_start), .single_cluster(single_cluster),
        .seq_idle(seq_idle), .seq_ok(seq_ok), .seq_fail(seq_fail),
        .launch(launch), .launch_core(launch_core), .launch_up(launch_up),
        .hold_busy(hold_busy), .done(seq_done), .err(seq_err)
    );

    pwr_step_fsm #(
        .NUM_CORES(NUM_CORES), .IDXW(IDXW), .SETTLE_CYC(SETTLE_CYC),
        .POLL_LIMIT(POLL_LIMIT), .MIN_RDY_CYCLES(MIN_RDY_CYCLES)
    ) step_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_core(launch_core),
        .launch_up(launch_up), .iso_ack(iso_ack), .sw_ack(sw_ack),
        .rdy_ack(rdy_ack), .por_ack(por_ack), .act(act), .act_core(act_core),
        .idle(seq_idle), .seq_ok(seq_ok), .seq_fail(seq_fail)
    );

    pwr_core_regs #(
        .NUM_CORES(NUM_CORES), .IDXW(IDXW)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .act(act), .act_core(act_core),
        .iso_en(iso_en), .pwr_sw_req(pwr_sw_req), .pwr_ready(pwr_ready),
        .por_hold(por_hold)
    );

    assign busy = !seq_idle || hold_busy;

endmodule

// File: rtl/core_pwr_seq_chk.sv
// Property checker for the power gating sequencer, bound to the top.
// Assumes: synchronous active-low reset on rst_n.
module core_pwr_seq_chk #(
    parameter int NUM_CORES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CORES-1:0] iso_en,
    input logic [NUM_CORES-1:0] pwr_sw_req,
    input logic [NUM_CORES-1:0] pwr_ready,
    input logic [NUM_CORES-1:0] por_hold,
    input logic                 busy,
    input logic                 seq_done,
    input logic                 seq_err
);
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_ord
        // R3
        sw_off_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pwr_sw_req[g]) |-> iso_en[g]);
        // R3
        por_after_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(por_hold[g]) |-> !pwr_ready[g]);
        // R4
        iso_release_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(iso_en[g]) |-> pwr_ready[g]);
        // R4
        por_release_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(por_hold[g]) |-> !iso_en[g]);
    end

    // R10
    done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err));
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done);
    // R10
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_err);
    // R9
    idle_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_done || seq_err) |=> !busy);

endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NUM_CORES(NUM_CORES)) chk_i (
    .clk(clk), .rst_n(rst_n), .iso_en(iso_en), .pwr_sw_req(pwr_sw_req),
    .pwr_ready(pwr_ready), .por_hold(por_hold), .busy(busy),
    .seq_done(seq_done), .seq_err(seq_err)
);

// File: tb/core_pwr_seq_tb_top.sv
`timescale 1ns/1ps
module core_pwr_seq_tb_top;
    localparam int NC   = 4;
    localparam int CPU  = 10;
    localparam int S    = CPU * 100;
    localparam int P    = 2000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_up = 1'b0, boot_start = 1'b0, single_cluster = 1'b0;
    logic [0:0] req_cluster = '0, req_local = '0;
    logic [NC-1:0] iso_ack, sw_ack, rdy_ack, por_ack;
    logic [NC-1:0] iso_en, pwr_sw_req, pwr_ready, por_hold;
    logic busy, seq_done, seq_err;

    int lat = 0;
    logic [NC-1:0] st_iso_m = '0, st_iso_v = '0, st_sw_m = '0, st_sw_v = '0;
    logic [NC-1:0] st_rdy_m = '0, st_rdy_v = '0, st_por_m = '0, st_por_v = '0;
    logic [NC-1:0] iso_h [0:31];
    logic [NC-1:0] sw_h  [0:31];
    logic [NC-1:0] rdy_h [0:31];
    logic [NC-1:0] por_h [0:31];

    int n_chk = 0, n_bad = 0, ncnt = 0;
    int t_iso [NC], t_sw [NC], t_rdy [NC], t_por [NC];
    logic [NC-1:0] p_iso, p_sw, p_rdy, p_por;

    always #2.5 clk = ~clk;

    core_pwr_seq #(.CLKS_PER_US(CPU)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cluster(req_cluster),
        .req_local(req_local), .req_up(req_up), .boot_start(boot_start),
        .single_cluster(single_cluster), .iso_ack(iso_ack), .sw_ack(sw_ack),
        .rdy_ack(rdy_ack), .por_ack(por_ack), .iso_en(iso_en),
        .pwr_sw_req(pwr_sw_req), .pwr_ready(pwr_ready), .por_hold(por_hold),
        .busy(busy), .seq_done(seq_done), .seq_err(seq_err)
    );

    // Acknowledge model: outputs delayed by lat cycles, with stuck overrides.
    always_ff @(posedge clk) begin
        iso_h[0] <= iso_en; sw_h[0] <= pwr_sw_req; rdy_h[0] <= pwr_ready; por_h[0] <= por_hold;
        for (int k = 1; k < 32; k++) begin
            iso_h[k] <= iso_h[k-1]; sw_h[k] <= sw_h[k-1];
            rdy_h[k] <= rdy_h[k-1]; por_h[k] <= por_h[k-1];
        end
    end
    always_comb begin
        int hi;
        hi = (lat > 0) ? lat - 1 : 0;
        iso_ack = ((lat == 0) ? iso_en     : iso_h[hi]) & ~st_iso_m | (st_iso_v & st_iso_m);
        sw_ack  = ((lat == 0) ? pwr_sw_req : sw_h[hi])  & ~st_sw_m  | (st_sw_v  & st_sw_m);
        rdy_ack = ((lat == 0) ? pwr_ready  : rdy_h[hi]) & ~st_rdy_m | (st_rdy_v & st_rdy_m);
        por_ack = ((lat == 0) ? por_hold   : por_h[hi]) & ~st_por_m | (st_por_v & st_por_m);
    end

    // Record the falling-edge count at which each core control last changed.
    always @(negedge clk) begin
        ncnt <= ncnt + 1;
        for (int c = 0; c < NC; c++) begin
            if (iso_en[c] !== p_iso[c])     t_iso[c] <= ncnt;
            if (pwr_sw_req[c] !== p_sw[c])  t_sw[c]  <= ncnt;
            if (pwr_ready[c] !== p_rdy[c])  t_rdy[c] <= ncnt;
            if (por_hold[c] !== p_por[c])   t_por[c] <= ncnt;
        end
        p_iso <= iso_en; p_sw <= pwr_sw_req; p_rdy <= pwr_ready; p_por <= por_hold;
    end

    task automatic chk(input string req, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Compare one core's {iso, sw, rdy, por} nibble.
    task automatic chk_core(input string req, input int c, input logic [3:0] exp);
        logic [3:0] a;
        a = {iso_en[c], pwr_sw_req[c], pwr_ready[c], por_hold[c]};
        chk(req, a === exp, int'(a), int'(exp));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 1'b0; boot_start = 1'b0; single_cluster = 1'b0; lat = 0;
        st_iso_m = '0; st_sw_m = '0; st_rdy_m = '0; st_por_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (35) @(negedge clk);
    endtask

    // Wait for the end pulse, returning the falling-edge count after acceptance.
    task automatic wait_end(input int limit, output int cyc, output bit d, output bit e);
        cyc = -1; d = 0; e = 0;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            if (seq_done || seq_err) begin
                cyc = i; d = seq_done; e = seq_err;
                break;
            end
        end
    endtask

    task automatic start_op(input bit up, input int cl, input int lc);
        req_up = up; req_cluster = cl[0:0]; req_local = lc[0:0]; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic after_pulse(input string req);
        @(negedge clk);
        chk(req, !seq_done && !seq_err && !busy, int'({seq_done, seq_err, busy}), 0);
    endtask

    task automatic run(input bit up, input int cl, input int lc, input int limit,
                       output int cyc, output bit d, output bit e);
        start_op(up, cl, lc);
        wait_end(limit, cyc, d, e);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 iso", iso_en === 4'h0, int'(iso_en), 0);
        chk("R1 sw", pwr_sw_req === 4'hF, int'(pwr_sw_req), 15);
        chk("R1 rdy", pwr_ready === 4'hF, int'(pwr_ready), 15);
        chk("R1 por", por_hold === 4'h0, int'(por_hold), 0);
        chk("R1 flags", {busy, seq_done, seq_err} === 3'b000, int'({busy, seq_done, seq_err}), 0);
    endtask

    task automatic t_down_basic();
        int cyc, t0; bit d, e;
        do_reset(); t0 = ncnt;
        run(0, 1, 0, 100, cyc, d, e);
        chk("R3 down done cycle", d && cyc == 7, cyc, 7);
        chk_core("R2 core2 off", 2, 4'b1001);
        chk_core("R2 core0 untouched", 0, 4'b0110);
        chk_core("R2 core3 untouched", 3, 4'b0110);
        chk("R3 order", t_iso[2] > t0 && t_iso[2] < t_sw[2] && t_sw[2] < t_rdy[2]
            && t_rdy[2] < t_por[2], t_por[2] - t_iso[2], 5);
        after_pulse("R10 down pulse");
    endtask

    task automatic t_down_lat();
        int cyc; bit d, e;
        do_reset(); lat = 3;
        run(0, 0, 1, 100, cyc, d, e);
        chk("R3 R5 down lat3", d && cyc == 16, cyc, 16);
        chk_core("R2 core1 off", 1, 4'b1001);
    endtask

    task automatic t_up(input int l, input int exp);
        int cyc, t0; bit d, e;
        do_reset();
        run(0, 1, 1, 100, cyc, d, e);
        repeat (2) @(negedge clk);
        lat = l; repeat (34) @(negedge clk);
        t0 = ncnt;
        run(1, 1, 1, 5000, cyc, d, e);
        chk("R4 up done cycle", d && !e && cyc == exp, cyc, exp);
        chk_core("R4 core3 running", 3, 4'b0110);
        chk("R4 order", t_sw[3] > t0 && t_rdy[3] - t_sw[3] >= S && t_rdy[3] < t_iso[3]
            && t_iso[3] < t_por[3], t_rdy[3] - t_sw[3], S + 1);
        after_pulse("R10 up pulse");
    endtask

    task automatic t_busy();
        int cyc = -1;
        do_reset();
        start_op(0, 1, 1);
        for (int i = 1; i <= 100; i++) begin
            @(negedge clk);
            if (i == 3) chk("R9 busy high", busy === 1'b1, int'(busy), 1);
            if (seq_done || seq_err) begin cyc = i; break; end
            if (i == 2) begin req_up = 1'b1; req_cluster = '0; req_local = '0; req_valid = 1'b1; end
            if (i == 4) req_valid = 1'b0;
        end
        chk("R9 done on time", cyc == 7, cyc, 7);
        repeat (20) @(negedge clk);
        chk("R9 late request dropped", !busy, int'(busy), 0);
        chk_core("R9 core0 untouched", 0, 4'b0110);
    endtask

    task automatic t_dn_stuck(input int kind);
        int cyc; bit d, e;
        do_reset();
        if (kind == 0) begin st_sw_m = 4'b0010; st_sw_v = 4'b0010; end
        if (kind == 1) begin st_iso_m = 4'b0010; st_iso_v = 4'b0000; end
        if (kind == 2) begin st_por_m = 4'b0010; st_por_v = 4'b0000; end
        run(0, 0, 1, 5000, cyc, d, e);
        if (kind == 0) begin
            chk("R6 switch wait abort", e && !d && cyc == 3 + P, cyc, 3 + P);
            chk_core("R6 later steps undone", 1, 4'b1010);
        end else if (kind == 1) begin
            chk("R6 iso wait tolerated", d && !e && cyc == 6 + P, cyc, 6 + P);
            chk_core("R6 R5 core1 off", 1, 4'b1001);
        end else begin
            chk("R6 reset wait abort", e && !d && cyc == 6 + P, cyc, 6 + P);
            chk_core("R6 core1 state", 1, 4'b1001);
        end
        after_pulse("R10 err pulse");
    endtask

    task automatic t_up_stuck(input int kind);
        int cyc; bit d, e;
        do_reset();
        run(0, 1, 0, 100, cyc, d, e);
        repeat (2) @(negedge clk);
        if (kind == 0) begin st_iso_m = 4'b0100; st_iso_v = 4'b0100; end
        if (kind == 1) begin st_rdy_m = 4'b0100; st_rdy_v = 4'b0000; end
        if (kind == 2) begin st_por_m = 4'b0100; st_por_v = 4'b0100; end
        run(1, 1, 0, 8000, cyc, d, e);
        if (kind == 0) begin
            chk("R7 iso clear tolerated", d && !e && cyc == 1021 + P, cyc, 1021 + P);
            chk_core("R7 core2 running", 2, 4'b0110);
        end else if (kind == 1) begin
            chk("R7 ready wait abort", e && !d && cyc == 2 + S + P, cyc, 2 + S + P);
            chk_core("R7 core2 held", 2, 4'b1111);
        end else begin
            chk("R7 reset release abort", e && !d && cyc == 1021 + P, cyc, 1021 + P);
            chk_core("R7 core2 state", 2, 4'b0110);
        end
    endtask

    task automatic t_sweep(input bit single, input bit fail);
        int cyc, t0; bit d, e;
        do_reset(); t0 = ncnt;
        single_cluster = single;
        if (fail) begin st_sw_m = 4'b0100; st_sw_v = 4'b0100; end
        boot_start = 1'b1; @(negedge clk); boot_start = 1'b0;
        wait_end(5000, cyc, d, e);
        chk_core("R8 core0 kept", 0, 4'b0110);
        chk_core("R8 core1 off", 1, 4'b1001);
        if (fail) begin
            chk("R8 stop at failure", e && !d && cyc == 12 + P, cyc, 12 + P);
            chk_core("R8 core3 skipped", 3, 4'b0110);
        end else if (single) begin
            chk("R8 single done", d && cyc == 7, cyc, 7);
            chk_core("R8 core2 skipped", 2, 4'b0110);
            chk_core("R8 core3 skipped", 3, 4'b0110);
        end else begin
            chk("R8 dual done once", d && cyc == 25, cyc, 25);
            chk_core("R8 core3 off", 3, 4'b1001);
            chk("R8 ascending", t_iso[1] > t0 && t_iso[2] - t_iso[1] == 9
                && t_iso[3] - t_iso[2] == 9, t_iso[3] - t_iso[1], 18);
        end
        after_pulse("R10 sweep pulse");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_down_basic();
        t_down_lat();
        t_up(0, 6 + S + 16);
        t_up(5, 6 + S + 10 + 16);
        t_up(20, 6 + S + 40 + 21);
        t_busy();
        t_dn_stuck(0);
        t_dn_stuck(1);
        t_dn_stuck(2);
        t_up_stuck(0);
        t_up_stuck(1);
        t_up_stuck(2);
        t_sweep(0, 0);
        t_sweep(1, 0);
        t_sweep(0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule